// File: doc/BRIEF.md
# SPI Register Access Target

This block is the serial front end of a register bank. A host opens a frame by raising chip select and clocks exactly 32 bits through it in SPI mode 0 (clock idles low, both sides sample on the rising edge, MSB first). The leading bit says whether the frame writes or reads. The next six bits pick one of 64 registers. One bit is spare, and the last 24 bits carry the payload.

The registers are not inside the block. It drives an address, a write-data bus and a one-cycle write strobe toward an external storage array, and it takes that array's read data back through a combinational read port. The serial inputs are synchronised into the system clock domain and their edges are detected there. The system clock is taken to be several times faster than the serial clock.

A read returns the addressed register later in the same frame. A write is committed only after the frame has closed with exactly 32 bits received.

Top module: `spi_reg_port`

## Requirements
- R1: Bits are taken from `mosi` on rising edges of `sclk` while `csel` is high, MSB first. The first bit of a frame is frame bit 31.
- R2: `csel` is active high. `sclk` edges while `csel` is low have no effect on later frames, and `miso` is 0 whenever `csel` is low.
- R3: Frame bit 31 equal to 1 marks a write. After a complete write frame, `regWrEn` pulses with `regAddr` equal to frame bits 30:25 and `regWrData` equal to frame bits 23:0.
- R4: Frame bit 31 equal to 0 marks a read. `miso` is 0 during frame bits 31:24, and during frame bits 23:0 it carries the 24-bit contents of the register at offset bits 30:25, MSB first. During a write frame `miso` stays 0.
- R5: `regWrEn` is high for exactly one system clock per committed write. It rises only after `csel` has fallen, and read frames never raise it.
- R6: A frame that closes with fewer or more than 32 bits received is discarded and causes no write.
- R7: Frame bit 24 has no effect on the address or the data of a write.
- R8: Once the seventh bit of a frame has been received, `regAddr` shows the frame's offset and holds it until the next frame's seventh bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| csel | input | 1 | Chip select, active high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| regAddr | output | 6 | Register offset toward the storage array |
| regWrData | output | 24 | Write data toward the storage array |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 24 | Combinational read data of the register at `regAddr` |

## Verification
The assertions assume that the serial clock is slow relative to the system clock. Each serial clock phase must span several system cycles, so that the address capture and the read-data load both finish before the falling edge that opens the data field. They also assume that chip select stays low for longer than the synchroniser delay plus one cycle between frames. The stimulus holds every serial clock phase for eight system cycles and leaves at least a dozen idle cycles after each frame. The only way it leaves the normal frame shape is through deliberate short frames, long frames and clock toggling while chip select is low.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // One-cycle strobes from the frame controller to the datapath.
  typedef struct packed {
    logic shiftIn;      // take one bit from the synchronised data line
    logic captureAddr;  // header complete: latch the register offset
    logic loadRead;     // sample the storage read port into the transmit shifter
    logic startTx;      // falling edge that opens the data field
    logic shiftTx;      // advance the transmit shifter by one bit
    logic clearTx;      // chip select is low: silence the output
    logic commit;       // frame closed with the exact bit count
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int ADDR_BITS   = 6,
  parameter int DATA_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         csel,
  input  logic         mosi,
  output ctrlStrobes_t strobes,
  output logic         mosiS
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] TX_OPEN   = CNT_W'(FRAME_BITS - DATA_BITS - 1);
  localparam logic [CNT_W-1:0] TX_SHIFT  = CNT_W'(FRAME_BITS - DATA_BITS);

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkS, csS;
  logic sclkPrev, csPrev;
  logic sclkRise, sclkFall, csEnd;
  logic [CNT_W-1:0] bitCount, fallCount;
  logic capPend, loadPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '0;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csel};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign csS   = csPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  assign sclkRise = csS & sclkS & ~sclkPrev;
  assign sclkFall = csS & ~sclkS & sclkPrev;
  assign csEnd    = ~csS & csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      csPrev    <= 1'b0;
      bitCount  <= '0;
      fallCount <= '0;
      capPend   <= 1'b0;
      loadPend  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
      capPend  <= sclkRise && (bitCount == HDR_LAST);
      loadPend <= capPend;
      if (!csS) begin
        bitCount  <= '0;
        fallCount <= '0;
      end else begin
        if (sclkRise && bitCount != CNT_SAT) bitCount <= bitCount + 1'b1;
        if (sclkFall && fallCount != CNT_SAT) fallCount <= fallCount + 1'b1;
      end
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.shiftIn     = sclkRise;
    strobes.captureAddr = capPend;
    strobes.loadRead    = loadPend;
    strobes.startTx     = sclkFall && (fallCount == TX_OPEN);
    strobes.shiftTx     = sclkFall && (fallCount >= TX_SHIFT);
    strobes.clearTx     = ~csS;
    strobes.commit      = csEnd && (bitCount == CNT_FULL);
  end

  // R4: the read port is sampled one cycle after the offset is latched
  assert_load_after_capture_R4 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRead |-> $past(strobes.captureAddr));

  // R2: a low chip select leaves no bit count behind for the next frame
  assert_count_cleared_R2 : assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> (bitCount == '0) && (fallCount == '0));

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int ADDR_BITS  = 6,
  parameter int DATA_BITS  = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 mosiS,
  input  logic                 csel,
  input  logic [DATA_BITS-1:0] regRdData,
  output logic [ADDR_BITS-1:0] regAddr,
  output logic [DATA_BITS-1:0] regWrData,
  output logic                 regWrEn,
  output logic                 miso
);

  localparam int HDR_FLAG = ADDR_BITS;  // flag position once the header has arrived

  logic [FRAME_BITS-1:0] rxShift;
  logic [ADDR_BITS-1:0]  addrQ;
  logic [DATA_BITS-1:0]  txShift;
  logic                  txActive;
  logic                  wrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      addrQ    <= '0;
      txShift  <= '0;
      txActive <= 1'b0;
      wrEnQ    <= 1'b0;
    end else begin
      if (strobes.shiftIn) rxShift <= {rxShift[FRAME_BITS-2:0], mosiS};
      if (strobes.captureAddr) addrQ <= rxShift[ADDR_BITS-1:0];
      if (strobes.loadRead)
        txShift <= rxShift[HDR_FLAG] ? '0 : regRdData;
      else if (strobes.shiftTx)
        txShift <= {txShift[DATA_BITS-2:0], 1'b0};
      if (strobes.clearTx) txActive <= 1'b0;
      else if (strobes.startTx) txActive <= 1'b1;
      wrEnQ <= strobes.commit & rxShift[FRAME_BITS-1];
    end
  end

  assign regAddr   = addrQ;
  assign regWrData = rxShift[DATA_BITS-1:0];
  assign regWrEn   = wrEnQ;
  assign miso      = csel & txActive & txShift[DATA_BITS-1];

  // R5: a committed write strobes for a single cycle
  assert_wr_single_R5 : assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R3: the offset does not move while a write is presented
  assert_wr_addr_stable_R3 : assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $stable(regAddr));

  // R4: the transmit shifter is never reloaded while it is driving the line
  assert_no_load_during_tx_R4 : assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> !strobes.loadRead);

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int ADDR_BITS   = 6,
  parameter int DATA_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csel,
  input  logic                 mosi,
  output logic                 miso,
  output logic [ADDR_BITS-1:0] regAddr,
  output logic [DATA_BITS-1:0] regWrData,
  output logic                 regWrEn,
  input  logic [DATA_BITS-1:0] regRdData
);

  ctrlStrobes_t strobes;
  logic         mosiS;

  spi_reg_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .ADDR_BITS  (ADDR_BITS),
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .csel   (csel),
    .mosi   (mosi),
    .strobes(strobes),
    .mosiS  (mosiS)
  );

  spi_reg_dp #(
    .FRAME_BITS(FRAME_BITS),
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mosiS    (mosiS),
    .csel     (csel),
    .regRdData(regRdData),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .miso     (miso)
  );

endmodule

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN, sclk, csel, mosi;
  logic        miso, regWrEn;
  logic [5:0]  regAddr;
  logic [23:0] regWrData, regRdData;
  logic [23:0] bank [64];
  logic [23:0] refMem [64];
  int          nChecks = 0, nFail = 0, nStrobes = 0, nExpStrobes = 0;
  int          qAddr[$];
  int          qData[$];
  bit          finished = 0;

  always #2 clk = ~clk;

  spi_reg_port i_spi_reg_port (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csel(csel), .mosi(mosi), .miso(miso),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData)
  );

  function automatic logic [23:0] seedVal(int i);
    return 24'(i * 72659) ^ 24'hA5C3E1;
  endfunction

  // storage array seen through the block's register port
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) bank[i] <= seedVal(i);
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
    end
  end
  assign regRdData = bank[regAddr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the queued write expectations
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (regWrEn) begin
        nStrobes++;
        if (csel) check("R5 strobe while csel high", 32'(csel), 32'd0);
        if (qAddr.size() == 0) begin
          check("R5 unexpected strobe", {8'd0, regAddr, 18'd0}, 32'hFFFFFFFF);
        end else begin
          int a, d;
          a = qAddr.pop_front();
          d = qData.pop_front();
          check("R3 write address", 32'(regAddr), 32'(a));
          check("R3 write data", 32'(regWrData), 32'(d));
        end
      end
      if (!csel && miso) check("R2 miso while csel low", 32'(miso), 32'd0);
    end
  end

  task automatic frame(input logic [31:0] word, input int nbits, output logic [31:0] got);
    got = '0;
    csel = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? word[31 - i] : 1'b1;
      repeat (HALF) @(negedge clk);
      got = {got[30:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csel = 1'b0;
    mosi = 1'b0;
    if (nbits == 32 && word[31]) begin
      qAddr.push_back(int'(word[30:25]));
      qData.push_back(int'(word[23:0]));
      refMem[word[30:25]] = word[23:0];
      nExpStrobes++;
    end
    repeat (14) @(negedge clk);
  endtask

  function automatic logic [31:0] rdWord(int off);
    return {1'b0, 6'(off), 1'b0, 24'h0};
  endfunction

  function automatic logic [31:0] wrWord(int off, logic [23:0] val, logic spare);
    return {1'b1, 6'(off), spare, val};
  endfunction

  task automatic readCheck(int off, string req);
    logic [31:0] got;
    frame(rdWord(off), 32, got);
    check(req, got, {8'h00, refMem[off]});
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    for (int i = 0; i < 64; i++) refMem[i] = seedVal(i);
    rstN = 1'b0; sclk = 1'b0; csel = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 reset strobe", 32'(regWrEn), 32'd0);
    check("R2 reset miso", 32'(miso), 32'd0);
    check("R8 reset address", 32'(regAddr), 32'd0);

    // R1 R4: reads of several offsets, MSB first, header bits return zero
    readCheck(5, "R4 read offset 5");
    readCheck(63, "R4 read offset 63");
    readCheck(0, "R1 read offset 0");
    check("R8 address held after read", 32'(regAddr), 32'd0);

    // R3: writes then read back, including all-zero and all-one payloads
    frame(wrWord(10, 24'hABCDEF, 1'b0), 32, got);
    check("R4 miso silent in write frame", got, 32'd0);
    check("R8 address after write", 32'(regAddr), 32'd10);
    readCheck(10, "R3 readback offset 10");
    frame(wrWord(33, 24'hFFFFFF, 1'b0), 32, got);
    frame(wrWord(62, 24'h000000, 1'b0), 32, got);
    readCheck(33, "R3 readback all ones");
    readCheck(62, "R3 readback all zeros");

    // R7: spare bit set has no effect
    frame(wrWord(0, 24'h13579B, 1'b1), 32, got);
    readCheck(0, "R7 spare bit ignored");
    frame({1'b0, 6'd33, 1'b1, 24'h0}, 32, got);
    check("R7 spare bit in read", got, {8'h00, refMem[33]});

    // R6: short and long frames are discarded
    frame(wrWord(10, 24'h111111, 1'b0), 20, got);
    frame(wrWord(10, 24'h222222, 1'b0), 31, got);
    frame(wrWord(10, 24'h333333, 1'b0), 33, got);
    readCheck(10, "R6 truncated and overlong frames discarded");

    // R2: clock toggles while deselected do not disturb the next frame
    mosi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 0;
    end
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
    readCheck(5, "R2 deselected clocks ignored");
    frame(wrWord(7, 24'hC0FFEE, 1'b0), 32, got);
    readCheck(7, "R2 write after deselected clocks");

    repeat (20) @(negedge clk);
    check("R5 strobe count", 32'(nStrobes), 32'(nExpStrobes));
    check("R5 pending writes", 32'(qAddr.size()), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule